// File: doc/BRIEF.md
# Fully Associative LRU Translation Cache

This block caches virtual-to-physical page translations in a small, fully associative array. Each slot holds a page base address, a page size given as a power of two, a physical base address and three attribute flags: user access, write permission and global. A client sends one command per accepted valid/ready handshake. The commands are probe (look up, with an optional recency update), fill, drop-all, drop-non-global and demap. Every command finishes in the cycle it is accepted.

Each slot has an age rank, and these ranks record recency explicitly. A fill goes to an empty slot if one exists. Only when the array is full does a fill overwrite the least recently used slot. A probe answers one cycle later with a hit or miss flag, the physical address with the page offset merged in, and the attribute flags of the matching slot. Selective flushing removes only the non-global translations, so global translations keep both their contents and their relative age.

Top module: `xlat_cache`

## Requirements
- R1: A valid slot matches a virtual address `va` when `base <= va < base + 2^shift`. `shift` is the page-size field, in the range 0 to VA_W-1. On a fill, the page base is stored with its low `shift` bits cleared, and so is the physical base.
- R2: On a hit, `rsp_pa` equals the stored physical base ORed with the low `shift` bits of the probed address, and `rsp_user`/`rsp_wr` equal the slot's flags.
- R3: `cmd_ready` is 1 out of reset. `rsp_valid` is 1 exactly in the cycle after an accepted probe (op code 0). On a miss, `rsp_miss`=1, `rsp_hit`=0, and `rsp_pa`, `rsp_user` and `rsp_wr` are all zero.
- R4: A fill (op code 1) uses an empty slot whenever one exists, so up to ENTRIES distinct fills after a flush all stay resident.
- R5: A fill into a full array replaces the least recently used slot.
- R6: A newly filled slot becomes the most recently used.
- R7: A probe that hits with `cmd_touch`=1 makes the hit slot the most recently used. A probe with `cmd_touch`=0 leaves the recency order unchanged.
- R8: Drop-all (op code 2) empties every slot.
- R9: Drop-non-global (op code 3) empties only the slots whose global flag is 0. Global slots stay resident and keep their relative age.
- R10: Demap (op code 4) empties the slot that a probe of `cmd_va` would hit, and does not change the recency order. If no slot matches, it has no effect.
- R11: When several slots match an address, the most recently used one answers.
- R12: Op codes 5, 6 and 7 are accepted and have no effect on contents or recency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 3 | Command code (0 probe, 1 fill, 2 drop-all, 3 drop-non-global, 4 demap) |
| cmd_touch | input | 1 | Probe updates recency on a hit |
| cmd_va | input | VA_W | Virtual address (probe, demap) or page base (fill) |
| cmd_pa | input | PA_W | Physical base for a fill |
| cmd_shift | input | SH_W | Log2 of the page size for a fill |
| cmd_user | input | 1 | User-access flag for a fill |
| cmd_wr | input | 1 | Write-permission flag for a fill |
| cmd_glob | input | 1 | Global flag for a fill |
| rsp_valid | output | 1 | Probe answer present |
| rsp_hit | output | 1 | Probe hit |
| rsp_miss | output | 1 | Probe missed |
| rsp_pa | output | PA_W | Translated physical address, zero on a miss |
| rsp_user | output | 1 | User-access flag of the hit slot |
| rsp_wr | output | 1 | Write-permission flag of the hit slot |

## Verification
The bench builds the block with ENTRIES=4, VA_W=16, PA_W=16 and SH_W=4. With only four slots, eviction begins on the fifth fill, so every recency path (promotion, quiet probe, selective flush, demap) changes which slot falls out within a few commands. The 16-bit address space lets the bench probe every address across a window that straddles a page, and the boundary addresses for every page size from 1 to 4096 bytes. A long pseudo-random command stream over a narrow address range then produces many overlapping pages, and a list-ordered reference model predicts each answer.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [2:0] {
    OP_PROBE      = 3'd0,
    OP_FILL       = 3'd1,
    OP_DROP_ALL   = 3'd2,
    OP_DROP_LOCAL = 3'd3,
    OP_DEMAP      = 3'd4
  } xlat_op_e;

  // Ones in the low sh bits.
  function automatic logic [31:0] span_mask(input logic [4:0] sh);
    span_mask = (32'd1 << sh) - 32'd1;
  endfunction

  // Range test: base <= va < base + 2^sh, computed one bit wider.
  function automatic logic covers(input logic [31:0] va, input logic [31:0] base,
                                  input logic [4:0] sh);
    logic [32:0] lim;
    lim = {1'b0, base} + (33'd1 << sh);
    covers = ({1'b0, va} >= {1'b0, base}) && ({1'b0, va} < lim);
  endfunction

  // Physical base with the page offset of va merged in.
  function automatic logic [31:0] join_pa(input logic [31:0] pbase, input logic [31:0] va,
                                          input logic [4:0] sh);
    join_pa = pbase | (va & span_mask(sh));
  endfunction

endpackage

// File: rtl/xlat_entry_match.sv
module xlat_entry_match #(
  parameter int VA_W = 16,
  parameter int SH_W = 4
) (
  input  logic            vld,
  input  logic [VA_W-1:0] va,
  input  logic [VA_W-1:0] base,
  input  logic [SH_W-1:0] shift,
  output logic            hit
);
  import xlat_pkg::*;

  assign hit = vld && covers(32'(va), 32'(base), 5'(shift));

endmodule

// File: rtl/xlat_pick.sv
module xlat_pick #(
  parameter int N  = 4,
  parameter int AW = 2
) (
  input  logic [N-1:0]    hits,
  input  logic [N*AW-1:0] ages,
  output logic [N-1:0]    win,
  output logic            any
);
  // A hit slot wins unless another hit slot is younger (smaller rank).
  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic beaten;
      beaten = 1'b0;
      for (int j = 0; j < N; j++) begin
        if (j != i && hits[j] && (ages[j*AW +: AW] < ages[i*AW +: AW])) beaten = 1'b1;
      end
      win[i] = hits[i] && !beaten;
    end
  end

  assign any = |hits;

endmodule

// File: rtl/xlat_alloc.sv
module xlat_alloc #(
  parameter int N  = 4,
  parameter int AW = 2
) (
  input  logic [N-1:0]    vld,
  input  logic [N*AW-1:0] ages,
  output logic [N-1:0]    victim
);
  localparam logic [AW-1:0] OLDEST = AW'(N - 1);

  logic [N-1:0] free;
  logic [N-1:0] lowest_free;
  logic [N-1:0] oldest;

  assign free        = ~vld;
  assign lowest_free = free & (~free + N'(1));

  for (genvar i = 0; i < N; i++) begin : g_old
    assign oldest[i] = (ages[i*AW +: AW] == OLDEST);
  end

  assign victim = (|free) ? lowest_free : oldest;

endmodule

// File: rtl/xlat_rank.sv
module xlat_rank #(
  parameter int N  = 4,
  parameter int AW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            promote,
  input  logic [N-1:0]    sel,
  output logic [N*AW-1:0] ages
);
  logic [AW-1:0] age_q [N];
  logic [AW-1:0] pivot;

  always_comb begin
    pivot = '0;
    for (int i = 0; i < N; i++) if (sel[i]) pivot = pivot | age_q[i];
  end

  for (genvar i = 0; i < N; i++) begin : g_age
    always_ff @(posedge clk) begin
      if (!rst_n)                    age_q[i] <= AW'(i);
      else if (promote) begin
        if (sel[i])                  age_q[i] <= '0;
        else if (age_q[i] < pivot)   age_q[i] <= age_q[i] + 1'b1;
      end
    end
    assign ages[i*AW +: AW] = age_q[i];
  end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = 4,
  parameter int VA_W    = 16,
  parameter int PA_W    = 16,
  parameter int SH_W    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2:0]      cmd_op,
  input  logic            cmd_touch,
  input  logic [VA_W-1:0] cmd_va,
  input  logic [PA_W-1:0] cmd_pa,
  input  logic [SH_W-1:0] cmd_shift,
  input  logic            cmd_user,
  input  logic            cmd_wr,
  input  logic            cmd_glob,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic            rsp_miss,
  output logic [PA_W-1:0] rsp_pa,
  output logic            rsp_user,
  output logic            rsp_wr
);
  import xlat_pkg::*;

  localparam int AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // Slot storage
  logic [ENTRIES-1:0] vld;
  logic [VA_W-1:0]    base_q [ENTRIES];
  logic [PA_W-1:0]    pa_q   [ENTRIES];
  logic [SH_W-1:0]    sh_q   [ENTRIES];
  logic [ENTRIES-1:0] user_q, wr_q, glob_q;

  // Named internal events
  logic                  accept, do_probe, do_fill, do_drop_all, do_drop_local, do_demap;
  logic [ENTRIES-1:0]    hit_vec, win_vec, fill_sel, promote_sel;
  logic                  any_hit, promote_en;
  logic [ENTRIES*AW-1:0] age_flat;

  assign cmd_ready     = 1'b1;
  assign accept        = cmd_valid && cmd_ready;
  assign do_probe      = accept && (cmd_op == OP_PROBE);
  assign do_fill       = accept && (cmd_op == OP_FILL);
  assign do_drop_all   = accept && (cmd_op == OP_DROP_ALL);
  assign do_drop_local = accept && (cmd_op == OP_DROP_LOCAL);
  assign do_demap      = accept && (cmd_op == OP_DEMAP);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    xlat_entry_match #(.VA_W(VA_W), .SH_W(SH_W)) u_match (
      .vld(vld[i]), .va(cmd_va), .base(base_q[i]), .shift(sh_q[i]), .hit(hit_vec[i])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)                              vld[i] <= 1'b0;
      else if (do_drop_all)                    vld[i] <= 1'b0;
      else if (do_drop_local && !glob_q[i])    vld[i] <= 1'b0;
      else if (do_demap && win_vec[i])         vld[i] <= 1'b0;
      else if (do_fill && fill_sel[i])         vld[i] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[i] <= '0; pa_q[i] <= '0; sh_q[i] <= '0;
        user_q[i] <= 1'b0; wr_q[i] <= 1'b0; glob_q[i] <= 1'b0;
      end else if (do_fill && fill_sel[i]) begin
        base_q[i] <= cmd_va & ~VA_W'(span_mask(5'(cmd_shift)));
        pa_q[i]   <= cmd_pa & ~PA_W'(span_mask(5'(cmd_shift)));
        sh_q[i]   <= cmd_shift;
        user_q[i] <= cmd_user;
        wr_q[i]   <= cmd_wr;
        glob_q[i] <= cmd_glob;
      end
    end
  end

  xlat_pick #(.N(ENTRIES), .AW(AW)) u_pick (
    .hits(hit_vec), .ages(age_flat), .win(win_vec), .any(any_hit)
  );

  xlat_alloc #(.N(ENTRIES), .AW(AW)) u_alloc (
    .vld(vld), .ages(age_flat), .victim(fill_sel)
  );

  assign promote_en  = do_fill || (do_probe && cmd_touch && any_hit);
  assign promote_sel = do_fill ? fill_sel : win_vec;

  xlat_rank #(.N(ENTRIES), .AW(AW)) u_rank (
    .clk(clk), .rst_n(rst_n), .promote(promote_en), .sel(promote_sel), .ages(age_flat)
  );

  // Winner data mux
  logic [PA_W-1:0] sel_pa;
  logic [SH_W-1:0] sel_sh;
  logic            sel_user, sel_wr;

  always_comb begin
    sel_pa = '0; sel_sh = '0; sel_user = 1'b0; sel_wr = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (win_vec[i]) begin
        sel_pa   = sel_pa | pa_q[i];
        sel_sh   = sel_sh | sh_q[i];
        sel_user = sel_user | user_q[i];
        sel_wr   = sel_wr | wr_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_miss <= 1'b0;
      rsp_pa <= '0; rsp_user <= 1'b0; rsp_wr <= 1'b0;
    end else begin
      rsp_valid <= do_probe;
      rsp_hit   <= do_probe && any_hit;
      rsp_miss  <= do_probe && !any_hit;
      rsp_pa    <= (do_probe && any_hit) ?
                   PA_W'(join_pa(32'(sel_pa), 32'(cmd_va), 5'(sel_sh))) : '0;
      rsp_user  <= do_probe && any_hit && sel_user;
      rsp_wr    <= do_probe && any_hit && sel_wr;
    end
  end

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int ENTRIES = 4,
  parameter int PA_W    = 16,
  parameter int AW      = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_valid,
  input logic                  cmd_ready,
  input logic [2:0]            cmd_op,
  input logic                  cmd_touch,
  input logic                  rsp_valid,
  input logic                  rsp_hit,
  input logic                  rsp_miss,
  input logic [PA_W-1:0]       rsp_pa,
  input logic [ENTRIES-1:0]    win_vec,
  input logic [ENTRIES-1:0]    vld,
  input logic [ENTRIES*AW-1:0] age_flat
);
  logic acc_probe, acc_drop_all, acc_bad_op;
  logic [ENTRIES-1:0] rank_seen;

  assign acc_probe    = cmd_valid && cmd_ready && (cmd_op == 3'd0);
  assign acc_drop_all = cmd_valid && cmd_ready && (cmd_op == 3'd2);
  assign acc_bad_op   = cmd_valid && cmd_ready && (cmd_op > 3'd4);

  always_comb begin
    rank_seen = '0;
    for (int i = 0; i < ENTRIES; i++) rank_seen[age_flat[i*AW +: AW]] = 1'b1;
  end

  AST_PROBE_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_probe |=> rsp_valid); // R3
  AST_NO_STRAY_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_probe |=> !rsp_valid); // R3
  AST_MISS_PA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (rsp_pa == '0 && !rsp_hit)); // R3
  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_vec)); // R11
  AST_QUIET_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_probe && !cmd_touch) |=> $stable(age_flat)); // R7
  AST_DROP_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_drop_all |=> (vld == '0)); // R8
  AST_RANKS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rank_seen) == ENTRIES); // R6
  AST_BAD_OP_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bad_op |=> ($stable(vld) && $stable(age_flat))); // R12

endmodule

bind xlat_cache xlat_cache_chk #(.ENTRIES(ENTRIES), .PA_W(PA_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_touch(cmd_touch), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_miss(rsp_miss), .rsp_pa(rsp_pa), .win_vec(win_vec), .vld(vld), .age_flat(age_flat)
);

// File: tb/sim_xlat_cache.sv
`timescale 1ns/1ps
module sim_xlat_cache;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 3'd0;
  logic        cmd_touch = 1'b0;
  logic [15:0] cmd_va = '0;
  logic [15:0] cmd_pa = '0;
  logic [3:0]  cmd_shift = '0;
  logic        cmd_user = 1'b0, cmd_wr = 1'b0, cmd_glob = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_user, rsp_wr;
  logic [15:0] rsp_pa;

  always #2.5 clk = ~clk;

  xlat_cache #(.ENTRIES(N), .VA_W(16), .PA_W(16), .SH_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_touch(cmd_touch), .cmd_va(cmd_va), .cmd_pa(cmd_pa),
    .cmd_shift(cmd_shift), .cmd_user(cmd_user), .cmd_wr(cmd_wr), .cmd_glob(cmd_glob),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_pa(rsp_pa),
    .rsp_user(rsp_user), .rsp_wr(rsp_wr)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // Reference: recency kept as an ordered list of slot numbers, most recent first.
  int m_vld[N], m_base[N], m_sh[N], m_pa[N], m_u[N], m_w[N], m_g[N], ord[N];
  int rng = 32'h1234567;

  function automatic int m_find(int va);
    for (int k = 0; k < N; k++) begin
      int s;
      s = ord[k];
      if (m_vld[s] != 0 && va >= m_base[s] && va < m_base[s] + (1 << m_sh[s])) return s;
    end
    return -1;
  endfunction

  task automatic m_front(int s);
    int p;
    p = 0;
    for (int k = 0; k < N; k++) if (ord[k] == s) p = k;
    for (int k = p; k > 0; k--) ord[k] = ord[k-1];
    ord[0] = s;
  endtask

  function automatic int next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >>> 17);
    rng = rng ^ (rng << 5);
    return rng & 32'h7fffffff;
  endfunction

  task automatic check(string tag, logic [35:0] got, logic [35:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic issue(int op, int touch, int va, int pa, int sh, int u, int w, int g);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_touch = touch[0];
    cmd_va = 16'(va); cmd_pa = 16'(pa); cmd_shift = 4'(sh);
    cmd_user = u[0]; cmd_wr = w[0]; cmd_glob = g[0];
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Probe and compare {valid, hit, miss, user, wr, pa}
  task automatic probe(string tag, int va, int touch);
    int s;
    logic [35:0] exp;
    s = m_find(va);
    if (s >= 0)
      exp = {12'h0, 1'b1, 1'b1, 1'b0, 1'(m_u[s]), 1'(m_w[s]), 3'b0,
             16'(m_pa[s] | (va & ((1 << m_sh[s]) - 1)))};
    else
      exp = {12'h0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'b0, 16'h0};
    issue(0, touch, va, 0, 0, 0, 0, 0);
    check(tag, {12'h0, rsp_valid, rsp_hit, rsp_miss, rsp_user, rsp_wr, 3'b0, rsp_pa}, exp);
    if (s >= 0 && touch != 0) m_front(s);
  endtask

  task automatic fill(int va, int pa, int sh, int u, int w, int g);
    int s;
    int msk;
    s = -1;
    for (int i = N - 1; i >= 0; i--) if (m_vld[i] == 0) s = i;
    if (s < 0) s = ord[N-1];
    msk = (1 << sh) - 1;
    m_vld[s] = 1; m_base[s] = va & ~msk & 16'hffff; m_pa[s] = pa & ~msk & 16'hffff;
    m_sh[s] = sh; m_u[s] = u; m_w[s] = w; m_g[s] = g;
    m_front(s);
    issue(1, 0, va, pa, sh, u, w, g);
    check("R3 no answer after fill", {35'h0, rsp_valid}, 36'h0);
  endtask

  task automatic drop_all();
    for (int i = 0; i < N; i++) m_vld[i] = 0;
    issue(2, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic drop_local();
    for (int i = 0; i < N; i++) if (m_g[i] == 0) m_vld[i] = 0;
    issue(3, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic demap(int va);
    int s;
    s = m_find(va);
    if (s >= 0) m_vld[s] = 0;
    issue(4, 0, va, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_g[i] = 0; ord[i] = i; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3 reset ready/valid", {34'h0, cmd_ready, rsp_valid}, 36'h2);
    probe("R3 miss after reset", 16'h1234, 1);

    // R1 R2: every address across a window around one 256-byte page
    fill(16'h1234, 16'h4567, 8, 1, 0, 0);
    for (int va = 16'h1000; va < 16'h1500; va++) probe("R1 R2 window sweep", va, 0);

    // R1: page edges for every size 1..4096 bytes
    for (int sh = 0; sh <= 12; sh++) begin
      drop_all();
      fill(16'h6000, 16'ha000 + sh, sh, sh & 1, (sh >> 1) & 1, 0);
      probe("R1 below base", 16'h5fff, 0);
      probe("R1 at base", 16'h6000, 0);
      probe("R1 last byte", 16'h6000 + (1 << sh) - 1, 0);
      probe("R1 past end", 16'h6000 + (1 << sh), 0);
    end

    // R4: four fills after a flush all stay resident
    drop_all();
    for (int k = 0; k < N; k++) fill(16'h0100 * (k + 1), 16'h8000 + k * 16'h100, 8, 1, 1, 0);
    for (int k = 0; k < N; k++) probe("R4 all resident", 16'h0100 * (k + 1) + 5, 0);
    // R5 R6: fifth fill evicts the oldest, newest stays
    fill(16'h0900, 16'hc000, 8, 0, 1, 0);
    probe("R5 oldest evicted", 16'h0105, 0);
    probe("R6 new entry hits", 16'h0910, 0);
    for (int k = 1; k < N; k++) probe("R5 others stay", 16'h0100 * (k + 1), 0);

    // R7: touch promotes, quiet probe does not
    drop_all();
    for (int k = 0; k < N; k++) fill(16'h2000 + k * 16'h100, 16'h3000 + k * 16'h100, 8, 0, 0, 0);
    probe("R7 touch oldest", 16'h2000, 1);
    fill(16'h2800, 16'h7000, 8, 0, 0, 0);
    probe("R7 promoted survives", 16'h2000, 0);
    probe("R7 next oldest gone", 16'h2100, 0);
    probe("R7 quiet probe", 16'h2200, 0);
    fill(16'h2900, 16'h7100, 8, 0, 0, 0);
    probe("R7 quiet-probed evicted", 16'h2200, 0);

    // R8
    drop_all();
    for (int k = 0; k < 4; k++) probe("R8 all empty", 16'h2000 + k * 16'h100, 0);

    // R9: non-global flush keeps global entries and their order
    for (int k = 0; k < N; k++) fill(16'h4000 + k * 16'h100, 16'h5000 + k * 16'h100, 8, 1, 0, (k % 2 == 0) ? 1 : 0);
    drop_local();
    for (int k = 0; k < N; k++) probe("R9 selective flush", 16'h4000 + k * 16'h100 + 1, 0);
    fill(16'h4a00, 16'h1100, 8, 0, 0, 0);
    fill(16'h4b00, 16'h1200, 8, 0, 0, 0);
    fill(16'h4c00, 16'h1300, 8, 0, 0, 0);
    probe("R9 oldest global evicted", 16'h4000, 0);
    probe("R9 younger global stays", 16'h4200, 0);

    // R10: demap, miss demap, and no recency change
    drop_all();
    for (int k = 0; k < N; k++) fill(16'h8000 + k * 16'h100, 16'h0000 + k * 16'h100, 8, 0, 1, 0);
    demap(16'h8180);
    probe("R10 demapped gone", 16'h8100, 0);
    probe("R10 neighbour stays", 16'h8200, 0);
    demap(16'hf000);
    fill(16'h8100, 16'h0900, 8, 0, 1, 0);
    demap(16'h9000);
    fill(16'h8500, 16'h0a00, 8, 0, 1, 0);
    probe("R10 order unchanged by demap", 16'h8000, 0);
    probe("R10 later entry stays", 16'h8300, 0);

    // R11: overlapping pages, most recent answers
    drop_all();
    fill(16'h3000, 16'h9000, 12, 1, 0, 0);
    fill(16'h3400, 16'hd400, 8, 0, 1, 0);
    probe("R11 small page newer", 16'h3450, 0);
    probe("R11 big page only", 16'h3010, 1);
    probe("R11 big page now newer", 16'h3450, 0);

    // R12: undefined op codes change nothing
    for (int op = 5; op < 8; op++) issue(op, 1, 16'h3450, 16'hffff, 0, 1, 1, 1);
    probe("R12 contents intact", 16'h3450, 0);
    probe("R12 contents intact", 16'h3460, 0);

    // Mixed stream over a narrow range: overlaps, evictions, flushes
    drop_all();
    for (int t = 0; t < 3000; t++) begin
      int r, sel, va;
      r = next_rand();
      sel = r % 100;
      va = next_rand() & 16'h0fff;
      if (sel < 45) probe("R11 R7 mixed stream", va, (r >> 8) & 1);
      else if (sel < 75) fill(va, next_rand() & 16'hffff, next_rand() % 12,
                              (r >> 9) & 1, (r >> 10) & 1, (r >> 11) & 1);
      else if (sel < 78) drop_all();
      else if (sel < 86) drop_local();
      else if (sel < 96) demap(va);
      else issue(5 + (r >> 12) % 3, 1, va, 0, 3, 1, 1, 1);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule